// File: doc/BRIEF.md
# Maskable Interrupt Flag Register with Set and Clear Ports

This block keeps a 32-bit word of pending-interrupt flags. Only the twelve positions 15 down to 4 hold real flags; every other position reads as zero. Hardware request pulses set flags directly. An acknowledge vector clears a flag when its interrupt is taken. Software reaches the flags through two write-only ports: one sets flags and one clears them. Each port has a strobe and a 32-bit data word, and only the 1 bits in the data take effect.

A software write is first captured in a staging register and applied to the flags on the following edge. Its effect can therefore first be read two cycles after the write cycle, which leaves one delay slot. When several sources act on the same flag at the same apply edge, a fixed per-bit precedence decides the result. From strongest to weakest the order is: hardware request, staged set, staged clear or acknowledge.

Top module: `irq_flag_reg`

## Requirements
- R1: Bits 31..16 and 3..0 of `flags_o` always read 0, and set-port or clear-port writes to those positions have no effect.
- R2: A clear-port write with a 1 in bit b (4..15) clears flag b. A 0 in bit b leaves flag b unchanged.
- R3: A set-port write with a 1 in bit b (4..15) sets flag b. A 0 in bit b leaves flag b unchanged.
- R4: A set-port or clear-port write with its strobe high in cycle n changes `flags_o` first in cycle n+2. In cycle n+1, `flags_o` still shows the old value.
- R5: Request bit k of `irq_req_i` (k = 0..11) maps to flag 4+k. A request sampled at an edge sets that flag, and the flag is visible in the next cycle.
- R6: A hardware request on a bit overrides a staged clear of the same bit that is applied at the same edge, so the flag ends up set.
- R7: When the set port and the clear port both write 1 to the same bit in the same cycle, the clear is ignored and the flag is set.
- R8: Acknowledge bit k of `irq_ack_i` (one-hot, k = 0..11) clears flag 4+k. A hardware request on the same bit at the same edge overrides the acknowledge.
- R9: A synchronous active-high `rst` clears every flag and discards any staged set or clear operation.
- R10: A staged set applied at the same edge as an acknowledge of the same bit leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 12 | Hardware request pulses; bit k targets flag 4+k |
| irq_ack_i | input | 12 | One-hot acknowledge; bit k clears flag 4+k |
| set_we_i | input | 1 | Set-port write strobe |
| set_data_i | input | 32 | Set-port data; 1 bits set flags |
| clr_we_i | input | 1 | Clear-port write strobe |
| clr_data_i | input | 32 | Clear-port data; 1 bits clear flags |
| flags_o | output | 32 | Readable flag word |

## Verification
Several properties are checked on every cycle: the reserved positions stay at zero, a request always leaves its flag set, a staged set beats every clear source, a flag rises only because of a request or a staged set, and reset empties both the staging register and the flag register. Some behaviour can only be shown by the bench's scenarios, because a single-cycle property cannot express it. This covers the exact two-cycle read latency, the old value still seen in the delay slot, and the outcome of every combination of request, set, clear and acknowledge for every bit position starting from both flag values.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_HW,
        ACT_SET,
        ACT_CLR,
        ACT_ACK
    } flag_act_e;

    // Per-bit precedence: request, then staged set, then staged clear, then acknowledge.
    function automatic flag_act_e pick_act(input logic req, input logic set,
                                           input logic clr, input logic ack);
        if (req)      return ACT_HW;
        else if (set) return ACT_SET;
        else if (clr) return ACT_CLR;
        else if (ack) return ACT_ACK;
        else          return ACT_HOLD;
    endfunction

endpackage

// File: rtl/sw_stage.sv
module sw_stage #(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] KEEP = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic [DATA_W-1:0] set_data,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] stg_set,
    output logic [DATA_W-1:0] stg_clr
);
    typedef struct packed {
        logic [DATA_W-1:0] set;
        logic [DATA_W-1:0] clr;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = '0;
        st_d.set = set_we ? (set_data & KEEP) : '0;
        st_d.clr = clr_we ? (clr_data & KEEP) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stg_set = st_q.set;
    assign stg_clr = st_q.clr;

    // R9: reset discards any staged operation
    p_stage_reset_r9: assert property (@(posedge clk) rst |=> (stg_set == '0 && stg_clr == '0));

    // R1: staged operations never reach reserved positions
    p_stage_reserved_r1: assert property (@(posedge clk) disable iff (rst)
        ((stg_set | stg_clr) & ~KEEP) == '0);

    // R4: a write lands in staging one edge later, not directly in the flags
    p_stage_capture_r4: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((stg_set & KEEP) == ($past(set_data) & KEEP)));

endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import irq_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] KEEP = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] req_i,
    input  logic [DATA_W-1:0] ack_i,
    input  logic [DATA_W-1:0] stg_set_i,
    input  logic [DATA_W-1:0] stg_clr_i,
    output logic [DATA_W-1:0] flags_o
);
    flag_act_e         act [DATA_W];
    logic [DATA_W-1:0] flags_d, flags_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_act
        assign act[i] = pick_act(req_i[i], stg_set_i[i], stg_clr_i[i], ack_i[i]);
    end

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < DATA_W; i++) begin
            case (act[i])
                ACT_HW, ACT_SET:  flags_d[i] = 1'b1;
                ACT_CLR, ACT_ACK: flags_d[i] = 1'b0;
                default:          flags_d[i] = flags_q[i];
            endcase
        end
        flags_d = flags_d & KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R9: reset empties the flag register
    p_flags_reset_r9: assert property (@(posedge clk) rst |=> flags_q == '0);

    // R5/R6: a request always leaves its flag set, whatever else acts on it
    p_hw_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (req_i & KEEP) != '0 |=> (flags_q & $past(req_i & KEEP)) == $past(req_i & KEEP));

    // R7/R10: a staged set beats staged clear and acknowledge
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        stg_set_i != '0 |=> (flags_q & $past(stg_set_i)) == $past(stg_set_i));

    // R2: a staged clear without any setting source empties the flag
    p_clear_applied_r2: assert property (@(posedge clk) disable iff (rst)
        (stg_clr_i & ~req_i & ~stg_set_i) != '0 |=>
            (flags_q & $past(stg_clr_i & ~req_i & ~stg_set_i)) == '0);

    // R8: an acknowledge without any setting source empties the flag
    p_ack_applied_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_i & ~req_i & ~stg_set_i) != '0 |=>
            (flags_q & $past(ack_i & ~req_i & ~stg_set_i)) == '0);

    // R3: a flag only rises because of a request or a staged set
    p_rise_cause_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (flags_q & ~$past(flags_q) & ~$past(req_i | stg_set_i)) == '0);

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int DATA_W  = 32,
    parameter int FLAG_LO = 4,
    parameter int FLAG_HI = 15,
    localparam int NF     = FLAG_HI - FLAG_LO + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NF-1:0]     irq_req_i,
    input  logic [NF-1:0]     irq_ack_i,
    input  logic              set_we_i,
    input  logic [DATA_W-1:0] set_data_i,
    input  logic              clr_we_i,
    input  logic [DATA_W-1:0] clr_data_i,
    output logic [DATA_W-1:0] flags_o
);
    localparam logic [DATA_W-1:0] KEEP = ((DATA_W'(1) << NF) - DATA_W'(1)) << FLAG_LO;

    logic [DATA_W-1:0] req_w, ack_w, stg_set, stg_clr;

    assign req_w = DATA_W'(irq_req_i) << FLAG_LO;
    assign ack_w = DATA_W'(irq_ack_i) << FLAG_LO;

    sw_stage #(.DATA_W(DATA_W), .KEEP(KEEP)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .set_we   (set_we_i),
        .set_data (set_data_i),
        .clr_we   (clr_we_i),
        .clr_data (clr_data_i),
        .stg_set  (stg_set),
        .stg_clr  (stg_clr)
    );

    flag_bank #(.DATA_W(DATA_W), .KEEP(KEEP)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_w),
        .ack_i     (ack_w),
        .stg_set_i (stg_set),
        .stg_clr_i (stg_clr),
        .flags_o   (flags_o)
    );

    // R1: reserved positions of the readable word stay at zero
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (flags_o & ~KEEP) == '0);

    // R8: acknowledge is one-hot or idle
    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack_i));

endmodule

// File: tb/tb_irq_flag_reg.sv
module tb_irq_flag_reg;
    localparam logic [31:0] MASK = 32'h0000_FFF0;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] irq_req_i, irq_ack_i;
    logic        set_we_i, clr_we_i;
    logic [31:0] set_data_i, clr_data_i, flags_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] m_flags, m_set, m_clr;

    always #2.5 clk = ~clk;

    irq_flag_reg dut (
        .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .irq_ack_i(irq_ack_i),
        .set_we_i(set_we_i), .set_data_i(set_data_i),
        .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .flags_o(flags_o)
    );

    task automatic check(input string tag);
        total++;
        if (flags_o !== m_flags) begin
            bad++;
            $display("FAIL %s: flags_o=%h expected=%h", tag, flags_o, m_flags);
        end
    endtask

    // One clock: drive after a falling edge, update model at the rising edge, compare after it.
    task automatic cyc(input logic [11:0] rq, input logic [11:0] ak,
                       input logic sw, input logic [31:0] sd,
                       input logic cw, input logic [31:0] cd, input string tag);
        irq_req_i = rq; irq_ack_i = ak;
        set_we_i = sw; set_data_i = sd; clr_we_i = cw; clr_data_i = cd;
        @(posedge clk);
        for (int b = 4; b < 16; b++) begin
            if (rq[b-4])      m_flags[b] = 1'b1;
            else if (m_set[b]) m_flags[b] = 1'b1;
            else if (m_clr[b]) m_flags[b] = 1'b0;
            else if (ak[b-4]) m_flags[b] = 1'b0;
        end
        m_set = sw ? (sd & MASK) : 32'h0;
        m_clr = cw ? (cd & MASK) : 32'h0;
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(input string tag);
        cyc(12'h0, 12'h0, 1'b0, 32'h0, 1'b0, 32'h0, tag);
    endtask

    function automatic string pick_tag(input int b, input bit rq, input bit s,
                                       input bit c, input bit a);
        if (b < 4 || b > 15) return "R1";
        if (rq && c)         return "R6";
        if (rq && a)         return "R8";
        if (rq)              return "R5";
        if (s && c)          return "R7";
        if (s && a)          return "R10";
        if (a)               return "R8";
        if (c)               return "R2";
        if (s)               return "R3";
        return "R2";
    endfunction

    initial begin
        rst = 1'b1; irq_req_i = '0; irq_ack_i = '0;
        set_we_i = 1'b0; clr_we_i = 1'b0; set_data_i = '0; clr_data_i = '0;
        m_flags = '0; m_set = '0; m_clr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9");
        rst = 1'b0;

        // R1: writes of all ones reach only the maskable positions
        cyc(12'h0, 12'h0, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, "R4");
        idle("R1");
        cyc(12'h0, 12'h0, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R4");
        idle("R2");

        // R4: delay slot explicitly, then effect
        cyc(12'h0, 12'h0, 1'b1, 32'h0000_0A50, 1'b0, 32'h0, "R4");
        idle("R4");
        idle("R3");

        // Exhaustive per-bit sweep of request/set/clear/ack from both start values
        for (int b = 0; b < 32; b++) begin
            for (int init = 0; init < 2; init++) begin
                for (int combo = 0; combo < 16; combo++) begin
                    automatic bit s  = combo[0];
                    automatic bit c  = combo[1];
                    automatic bit rq = combo[2];
                    automatic bit a  = combo[3];
                    automatic logic [31:0] one = 32'h1 << b;
                    automatic logic [11:0] rv = (b >= 4 && b <= 15 && rq) ? (12'h1 << (b-4)) : 12'h0;
                    automatic logic [11:0] av = (b >= 4 && b <= 15 && a)  ? (12'h1 << (b-4)) : 12'h0;
                    if (init == 1) cyc(12'h0, 12'h0, 1'b1, one, 1'b0, 32'h0, "R4");
                    else           cyc(12'h0, 12'h0, 1'b0, 32'h0, 1'b1, one, "R4");
                    idle(init == 1 ? "R3" : "R2");
                    cyc(12'h0, 12'h0, s, one, c, one, "R4");
                    cyc(rv, av, 1'b0, 32'h0, 1'b0, 32'h0, pick_tag(b, rq, s, c, a));
                    idle(pick_tag(b, rq, s, c, a));
                end
            end
        end

        // R9: reset discards a staged set
        cyc(12'h0, 12'h0, 1'b1, 32'h0000_FFF0, 1'b0, 32'h0, "R4");
        rst = 1'b1;
        @(posedge clk);
        m_flags = '0; m_set = '0; m_clr = '0;
        @(negedge clk);
        rst = 1'b0;
        check("R9");
        idle("R9");
        idle("R9");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule